// File: doc/BRIEF.md
# Microstep Position Translator with Per-Phase Decay Request

This block turns a stream of step pulses into current commands for the two windings of a bipolar stepper motor. It keeps a position index that walks around a 32-slot electrical cycle, one slot per 11.25 degrees. Each rising edge of the step input moves the index forward or backward by 8, 4, 2 or 1 slots, depending on the resolution select and the direction input. For each winding the block outputs three things: a magnitude code, a polarity bit and a scaled unsigned current level. Winding A follows the cosine of the electrical angle and winding B follows the sine.

For each winding the block also outputs a current-decay request. The request is set again on every accepted step. When the new magnitude is below the previous one, the winding takes the externally chosen decay mode. Otherwise it takes slow decay. A home flag marks the 45-degree rest position. An active-low hold input parks the translator at home and drops the driver enable. A synchronous power-on/undervoltage reset does the same.

Top module: `ustep_xlator`

## Requirements
- R1: `res_sel` is {MS2-like bit, MS1-like bit}. The values 00, 01, 10 and 11 advance the index by 8, 4, 2 and 1 slots per accepted step. The index wraps modulo 32.
- R2: The magnitude code k is 0 to 8 and maps to 100.00, 98.08, 92.39, 83.15, 70.71, 55.56, 38.27, 19.51 and 0.00 percent. `*_lvl` is that percent of (2^LVL_W-1), rounded to nearest. For index p, phase A has k = p mod 16 when that is at most 8, and 16 - (p mod 16) otherwise. Phase B uses the same rule on (p - 8) mod 32.
- R3: `a_neg` is 1 exactly when the index is 9 to 23. `b_neg` is 1 exactly when the index is 17 to 31. A zero-magnitude phase has polarity 0.
- R4: When `dir_in` is 1 at the step, the index increases. When `dir_in` is 0, the index decreases.
- R5: Home is index 4, where both phases are at code 4 with positive polarity. `at_home_n` is 0 exactly while the index is home.
- R6: While `hold_n` is 0, the index is forced home and `drv_en` is 0. Both decay outputs are mixed, and step edges are ignored. One cycle after `hold_n` returns to 1, `drv_en` is 1.
- R7: `rst` (synchronous, active high) gives the same home state as R6, with both decay outputs mixed.
- R8: `res_sel` and `dir_in` act only at an accepted step edge. Changing them between steps leaves every output unchanged.
- R9: Decay encoding is 00 slow, 01 fast, 10 mixed. A `decay_cfg` of 11 is read as mixed. On each step, a phase whose code grows (lower current) takes `decay_cfg`, and a phase whose code is equal or smaller takes slow. The decay outputs hold their value between steps.
- R10: In full-step mode (`res_sel` 00), the next index is the nearest slot of the form 8n+4 strictly in the chosen direction.
- R11: Each rising edge of `step_in` gives exactly one advance, however long the input stays high. The outputs change on the third rising clock edge after `step_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on/undervoltage reset, active high |
| hold_n | input | 1 | Park-at-home and disable, active low |
| step_in | input | 1 | Asynchronous step pulse |
| dir_in | input | 1 | Travel direction (1 = increasing angle) |
| res_sel | input | 2 | Step resolution select |
| decay_cfg | input | 2 | Decay mode used when current falls |
| drv_en | output | 1 | Bridge enable request |
| at_home_n | output | 1 | Low at home position |
| a_code | output | 4 | Phase A magnitude code |
| a_neg | output | 1 | Phase A polarity (1 = negative) |
| a_lvl | output | LVL_W | Phase A scaled current level |
| a_decay | output | 2 | Phase A decay request |
| b_code | output | 4 | Phase B magnitude code |
| b_neg | output | 1 | Phase B polarity |
| b_lvl | output | LVL_W | Phase B scaled current level |
| b_decay | output | 2 | Phase B decay request |

## Verification
A corrupted position index shows up directly in the magnitude codes and polarities of both phases on the very next registered update. It also breaks the rule that the two codes sum to eight. A wrong step-size decode or a missed full-step snap becomes visible on the same step as a wrong code pair. A wrong decay comparison shows only on steps where a phase's magnitude falls or rises, so the random stream runs many mixed-direction steps at every resolution to reach both cases. A synchroniser that double-fires appears as two index moves from one long pulse, and a long-pulse test catches this within a single step.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int POS_W    = 5;
  localparam int CODE_W   = 4;
  localparam int NSLOT    = 1 << POS_W;
  localparam int QUARTER  = NSLOT / 4;
  localparam int HALFQ    = QUARTER / 2;
  localparam int NCODE    = QUARTER + 1;
  localparam int HOME_POS = HALFQ;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10
  } decay_e;

  function automatic decay_e norm_decay(input logic [1:0] raw);
    case (raw)
      2'b00:   return DK_SLOW;
      2'b01:   return DK_FAST;
      default: return DK_MIXED;
    endcase
  endfunction

  // hundredths of a percent of full trip current, by magnitude code
  function automatic int pct_x100(input int k);
    case (k)
      0:       return 10000;
      1:       return 9808;
      2:       return 9239;
      3:       return 8315;
      4:       return 7071;
      5:       return 5556;
      6:       return 3827;
      7:       return 1951;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ustep_step_sync.sv
module ustep_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ustep_pos_seq.sv
module ustep_pos_seq
  import ustep_pkg::*;
(
  input  logic [POS_W-1:0] pos,
  input  logic             dir,
  input  logic [1:0]       res_sel,
  output logic [POS_W-1:0] nxt
);
  localparam logic [POS_W-1:0] FULL_AMT = POS_W'(QUARTER);
  localparam logic [2:0]       MID      = 3'(HALFQ);

  logic [POS_W-1:0] amt;
  logic [1:0]       oct;
  logic [2:0]       low;

  always_comb begin
    amt = FULL_AMT >> res_sel;
    oct = pos[POS_W-1:3];
    low = pos[2:0];
    if (res_sel == 2'b00) begin
      // full step: land on next 8n+4 slot in travel direction
      if (dir) nxt = (low < MID) ? {oct, MID} : {oct + 2'd1, MID};
      else     nxt = (low > MID) ? {oct, MID} : {oct - 2'd1, MID};
    end else begin
      nxt = dir ? pos + amt : pos - amt;
    end
  end
endmodule

// File: rtl/ustep_phase_map.sv
module ustep_phase_map
  import ustep_pkg::*;
#(
  parameter int OFFSET = 0,
  parameter int LVL_W  = 8
) (
  input  logic [POS_W-1:0]  pos,
  output logic [CODE_W-1:0] code,
  output logic              neg,
  output logic [LVL_W-1:0]  lvl
);
  localparam int MAXV = (1 << LVL_W) - 1;

  logic [LVL_W-1:0] lvl_tab [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign lvl_tab[g] = LVL_W'((pct_x100(g) * MAXV + 5000) / 10000);
  end

  logic [POS_W-1:0]  q;
  logic [CODE_W-1:0] m;

  always_comb begin
    q    = pos - POS_W'(OFFSET);
    m    = q[CODE_W-1:0];
    code = (m <= CODE_W'(QUARTER)) ? m : (CODE_W'(0) - m);
    neg  = (q > POS_W'(QUARTER)) && (q < POS_W'(3 * QUARTER));
    lvl  = lvl_tab[code];
  end
endmodule

// File: rtl/ustep_decay_pick.sv
module ustep_decay_pick
  import ustep_pkg::*;
(
  input  logic [CODE_W-1:0] old_code,
  input  logic [CODE_W-1:0] new_code,
  input  decay_e            cfg,
  output decay_e            mode
);
  // larger code means smaller current
  always_comb mode = (new_code > old_code) ? cfg : DK_SLOW;
endmodule

// File: rtl/ustep_xlator.sv
module ustep_xlator
  import ustep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [1:0]       res_sel,
  input  logic [1:0]       decay_cfg,
  output logic             drv_en,
  output logic             at_home_n,
  output logic [3:0]       a_code,
  output logic             a_neg,
  output logic [LVL_W-1:0] a_lvl,
  output logic [1:0]       a_decay,
  output logic [3:0]       b_code,
  output logic             b_neg,
  output logic [LVL_W-1:0] b_lvl,
  output logic [1:0]       b_decay
);
  localparam int NPH = 2;
  localparam logic [POS_W-1:0] HOME = POS_W'(HOME_POS);

  logic             rise, take, park;
  logic [POS_W-1:0] pos_q, pos_d, pos_sel;
  decay_e           cfg_e;

  logic [CODE_W-1:0] code_n [NPH];
  logic              neg_n  [NPH];
  logic [LVL_W-1:0]  lvl_n  [NPH];
  decay_e            dk_n   [NPH];

  logic [CODE_W-1:0] code_q [NPH];
  logic              neg_q  [NPH];
  logic [LVL_W-1:0]  lvl_q  [NPH];
  decay_e            dk_q   [NPH];
  logic              en_q, home_n_q;

  ustep_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(step_in), .rise(rise)
  );

  ustep_pos_seq u_seq (
    .pos(pos_q), .dir(dir_in), .res_sel(res_sel), .nxt(pos_d)
  );

  assign park    = rst || !hold_n;
  assign take    = rise && hold_n;
  assign cfg_e   = norm_decay(decay_cfg);
  assign pos_sel = park ? HOME : (take ? pos_d : pos_q);

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    ustep_phase_map #(.OFFSET(g * QUARTER), .LVL_W(LVL_W)) u_map (
      .pos(pos_sel), .code(code_n[g]), .neg(neg_n[g]), .lvl(lvl_n[g])
    );
    ustep_decay_pick u_dk (
      .old_code(code_q[g]), .new_code(code_n[g]), .cfg(cfg_e), .mode(dk_n[g])
    );
  end

  always_ff @(posedge clk) begin
    pos_q    <= pos_sel;
    home_n_q <= (pos_sel != HOME);
    en_q     <= rst ? 1'b0 : hold_n;
    for (int i = 0; i < NPH; i++) begin
      code_q[i] <= code_n[i];
      neg_q[i]  <= neg_n[i];
      lvl_q[i]  <= lvl_n[i];
      if (park)      dk_q[i] <= DK_MIXED;
      else if (take) dk_q[i] <= dk_n[i];
    end
  end

  assign drv_en    = en_q;
  assign at_home_n = home_n_q;
  assign a_code    = code_q[0];
  assign a_neg     = neg_q[0];
  assign a_lvl     = lvl_q[0];
  assign a_decay   = dk_q[0];
  assign b_code    = code_q[1];
  assign b_neg     = neg_q[1];
  assign b_lvl     = lvl_q[1];
  assign b_decay   = dk_q[1];
endmodule

// File: rtl/ustep_xlator_chk.sv
module ustep_xlator_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold_n,
  input logic       drv_en,
  input logic       at_home_n,
  input logic [3:0] a_code,
  input logic       a_neg,
  input logic [1:0] a_decay,
  input logic [3:0] b_code,
  input logic       b_neg,
  input logic [1:0] b_decay
);
  // R5
  home_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!at_home_n) == (a_code == 4'd4 && b_code == 4'd4 && !a_neg && !b_neg));

  // R2
  quad_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (5'(a_code) + 5'(b_code)) == 5'd8);

  // R6
  hold_park_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> (!drv_en && !at_home_n && a_decay == 2'b10 && b_decay == 2'b10));

  // R11
  single_move_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_n && $past(hold_n) && !$past(rst) &&
     !$stable({a_code, b_code, a_neg, b_neg}))
    |=> $stable({a_code, b_code, a_neg, b_neg}));

  // R9
  rise_slow_a_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_n && $past(hold_n) && !$past(rst) && a_code < $past(a_code))
    |-> a_decay == 2'b00);

  // R9
  rise_slow_b_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_n && $past(hold_n) && !$past(rst) && b_code < $past(b_code))
    |-> b_decay == 2'b00);
endmodule

bind ustep_xlator ustep_xlator_chk u_chk (
  .clk(clk), .rst(rst), .hold_n(hold_n), .drv_en(drv_en),
  .at_home_n(at_home_n), .a_code(a_code), .a_neg(a_neg), .a_decay(a_decay),
  .b_code(b_code), .b_neg(b_neg), .b_decay(b_decay)
);

// File: tb/ustep_xlator_test.sv
`timescale 1ns/1ps
module ustep_xlator_test;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_n = 1'b1;
  logic step_in = 1'b0;
  logic dir_in = 1'b1;
  logic [1:0] res_sel = 2'b11;
  logic [1:0] decay_cfg = 2'b10;
  logic drv_en, at_home_n, a_neg, b_neg;
  logic [3:0] a_code, b_code;
  logic [LW-1:0] a_lvl, b_lvl;
  logic [1:0] a_decay, b_decay;

  always #2.5 clk = ~clk;

  ustep_xlator #(.SYNC_STAGES(2), .LVL_W(LW)) uut (
    .clk(clk), .rst(rst), .hold_n(hold_n), .step_in(step_in), .dir_in(dir_in),
    .res_sel(res_sel), .decay_cfg(decay_cfg), .drv_en(drv_en), .at_home_n(at_home_n),
    .a_code(a_code), .a_neg(a_neg), .a_lvl(a_lvl), .a_decay(a_decay),
    .b_code(b_code), .b_neg(b_neg), .b_lvl(b_lvl), .b_decay(b_decay)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int m_pos = 4;
  int m_ad = 2;
  int m_bd = 2;
  int m_en = 0;

  function automatic int f_code(int p, int off);
    int q = (p - off) & 31;
    int m = q & 15;
    return (m <= 8) ? m : 16 - m;
  endfunction

  function automatic int f_neg(int p, int off);
    int q = (p - off) & 31;
    return (q > 8 && q < 24) ? 1 : 0;
  endfunction

  function automatic int f_lvl(int k);
    int pct[9] = '{10000, 9808, 9239, 8315, 7071, 5556, 3827, 1951, 0};
    return (pct[k] * 255 + 5000) / 10000;
  endfunction

  function automatic int f_next(int p, int d, int rs);
    int low = p & 7;
    int oct = p >> 3;
    if (rs == 0) begin
      if (d != 0) return (low < 4) ? ((oct << 3) | 4) : ((((oct + 1) & 3) << 3) | 4);
      else        return (low > 4) ? ((oct << 3) | 4) : ((((oct + 3) & 3) << 3) | 4);
    end
    return (d != 0) ? ((p + (8 >> rs)) & 31) : ((p - (8 >> rs)) & 31);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R6 drv_en"}, int'(drv_en), m_en);
    chk({ctx, " R5 at_home_n"}, int'(at_home_n), (m_pos == 4) ? 0 : 1);
    chk({ctx, " R2 a_code"}, int'(a_code), f_code(m_pos, 0));
    chk({ctx, " R2 b_code"}, int'(b_code), f_code(m_pos, 8));
    chk({ctx, " R2 a_lvl"}, int'(a_lvl), f_lvl(f_code(m_pos, 0)));
    chk({ctx, " R2 b_lvl"}, int'(b_lvl), f_lvl(f_code(m_pos, 8)));
    chk({ctx, " R3 a_neg"}, int'(a_neg), f_neg(m_pos, 0));
    chk({ctx, " R3 b_neg"}, int'(b_neg), f_neg(m_pos, 8));
    chk({ctx, " R9 a_decay"}, int'(a_decay), m_ad);
    chk({ctx, " R9 b_decay"}, int'(b_decay), m_bd);
  endtask

  task automatic model_step(int d, int rs, int cfg);
    int np = f_next(m_pos, d, rs);
    int c = (cfg == 3) ? 2 : cfg;
    m_ad = (f_code(np, 0) > f_code(m_pos, 0)) ? c : 0;
    m_bd = (f_code(np, 8) > f_code(m_pos, 8)) ? c : 0;
    m_pos = np;
  endtask

  task automatic do_step(int d, int rs, int cfg, int hi_len);
    @(negedge clk);
    dir_in = d[0]; res_sel = rs[1:0]; decay_cfg = cfg[1:0];
    @(negedge clk);
    step_in = 1'b1;
    repeat (hi_len) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    if (hold_n) model_step(d, rs, cfg);
  endtask

  task automatic park_model();
    m_pos = 4; m_ad = 2; m_bd = 2;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    park_model(); m_en = 1;
    check_all("R7 reset");

    // R1 eighth, quarter, half steps forward
    do_step(1, 3, 1, 4); check_all("R1 eighth");
    do_step(1, 2, 1, 4); check_all("R1 quarter");
    do_step(1, 1, 1, 4); check_all("R1 half");
    // R10 full step snap from an off-grid slot (index 11 -> 12)
    do_step(1, 0, 1, 4); check_all("R10 snap fwd");
    do_step(1, 3, 1, 4); check_all("R1 eighth");
    do_step(0, 0, 1, 4); check_all("R10 snap back");
    do_step(0, 0, 1, 4); check_all("R4 full back");
    do_step(0, 3, 2, 4); check_all("R4 eighth back");

    // R8 select changes without a step leave outputs alone
    @(negedge clk); res_sel = 2'b00; dir_in = 1'b0; decay_cfg = 2'b01;
    repeat (6) @(negedge clk);
    check_all("R8 no step");
    do_step(1, 2, 3, 4); check_all("R8 sampled at step");

    // R11 long pulse gives one move
    do_step(1, 3, 1, 20); check_all("R11 long pulse");

    // R9 sweep through a falling and a rising phase
    for (int i = 0; i < 8; i++) begin
      do_step(1, 3, i % 3, 4); check_all("R9 sweep");
    end

    // R6 hold parks, ignores steps
    @(negedge clk); hold_n = 1'b0;
    repeat (2) @(negedge clk);
    park_model(); m_en = 0;
    check_all("R6 held");
    do_step(1, 1, 1, 4); check_all("R6 step ignored");
    @(negedge clk); hold_n = 1'b1;
    repeat (2) @(negedge clk);
    m_en = 1;
    check_all("R6 released");

    // random stream
    for (int i = 0; i < 300; i++) begin
      int d = int'($urandom % 2);
      int rs = int'($urandom % 4);
      int cf = int'($urandom % 4);
      int hl = 4 + int'($urandom % 5);
      do_step(d, rs, cf, hl);
      check_all("R1 random");
    end

    // R7 reset mid-run returns to home with mixed decay
    do_step(1, 3, 0, 4);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    park_model(); m_en = 0;
    check_all("R7 in reset");
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    m_en = 1;
    check_all("R7 after reset");
    do_step(1, 0, 1, 4); check_all("R10 full from home");

    finished = 1;
    report();
    $finish;
  end
endmodule